// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block owns the operating mode of a CAN protocol engine around the bus-off condition. It holds a 16-bit mode control word written through a simple write strobe. It derives the current operating mode from that word and from its own bus-off state, and reports the mode to the rest of the controller. When the error-confinement logic signals that the node has gone bus-off, the block does one of two things. By default it stays bus-off and watches the sampled bus level at each bit-time strobe, until it has seen 128 runs of 11 consecutive recessive bits. If the control word enables it, it instead drops straight into halt mode by setting its own halt request bit.

The control word also polices its own writes. The identifier-order bit and the auto-halt bit change only in reset mode. The three-bit test field changes only in reset or halt mode. Three reserved bits always read zero. Bits 7..0 accept writes in any mode.

Top module: `can_busoff_recovery`

## Requirements
- R1: While `rst_n` is low (synchronous), the block goes to reset mode, the control word reads 0x0000 and `recovery_done` is 0. The block stays in reset mode until a control write with bit 0 clear. Any control write with bit 0 set enters reset mode from the next cycle.
- R2: `mode_out` encodes 0 = reset, 1 = halt, 2 = normal, 3 = bus-off. The priority is reset, then halt (control bit 1 set), then bus-off, then normal. The output follows the stored state combinationally.
- R3: Control bits 13..11 always read 0, whatever is written.
- R4: Control bits 15 (identifier order) and 14 (auto-halt on bus-off) take a written value only when the mode is reset in the cycle of the write. Otherwise they keep their value.
- R5: Control bits 10..8 (test field) take a written value only when the mode is reset or halt in the cycle of the write. In normal or bus-off mode they keep their value.
- R6: Control bits 7..0 (bit 6 = halt enable, bit 1 = halt request, bit 0 = reset request) take every written value in every mode.
- R7: A `busoff_enter` pulse in normal mode, with bit 14 or bit 6 clear, moves the block to bus-off mode in the next cycle. A pulse in any other mode has no effect.
- R8: A `busoff_enter` pulse in normal mode, with bits 14 and 6 both set, sets control bit 1 and gives halt mode in the next cycle. It does not start bus-off recovery.
- R9: In bus-off mode, each `bit_tick` with `bus_bit` = 1 (recessive) extends a run. Every 11 recessive ticks in a row complete one sequence. When the 128th sequence completes, the next cycle shows normal mode with `recovery_done` high for exactly one cycle.
- R10: A `bit_tick` with `bus_bit` = 0 (dominant) in bus-off mode discards the current run but keeps the completed sequences. `bus_bit` has no effect in a cycle without `bit_tick`.
- R11: Entering reset mode clears the bus-off state and all recovery progress. After the return to normal mode, a new bus-off needs the full 128 x 11 recessive ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| busoff_enter | input | 1 | Pulse: error confinement reached bus-off |
| mcr_wr_en | input | 1 | Control word write strobe |
| mcr_wdata | input | 16 | Control word write value |
| mcr_rdata | output | 16 | Current control word |
| mode_out | output | 2 | Operating mode (0 reset, 1 halt, 2 normal, 3 bus-off) |
| recovery_done | output | 1 | One-cycle pulse when bus-off recovery completes |

## Verification
The recovery counter is tried with one unbroken stream of 1408 recessive ticks. It is then tried with a stream broken by dominant bits: one after ten recessive bits, one partway through the fourth run. A count that fails to discard the partial run, or that also discards finished sequences, moves the completion tick and shows up in the bench. Dominant levels between strobes separate strobe gating from level sampling. A bus-off entered after a detour through reset mode must again take the full count, which exposes stale progress. The write rules are tried by writing all-ones and mixed words in each of reset, halt and normal mode. The two auto-halt enable bits are tried both set and with only one of them set.

// File: rtl/busoff_pkg.sv
// Package: shared mode encoding and control-word layout for the bus-off
// recovery controller. Assumes a 16-bit control word.
package busoff_pkg;

    typedef enum logic [1:0] {
        MODE_RESET  = 2'd0,
        MODE_HALT   = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_BUSOFF = 2'd3
    } ctl_mode_e;

    typedef enum logic [1:0] {
        WR_ANY,
        WR_RESET_ONLY,
        WR_RESET_HALT,
        WR_NEVER
    } wr_class_e;

    localparam int MCR_W         = 16;
    localparam int BIT_RST_REQ   = 0;
    localparam int BIT_HALT_REQ  = 1;
    localparam int BIT_HALT_EN   = 6;
    localparam int TEST_LO       = 8;
    localparam int TEST_HI       = 10;
    localparam int RSV_LO        = 11;
    localparam int RSV_HI        = 13;
    localparam int BIT_AUTO_HALT = 14;
    localparam int BIT_ID_ORDER  = 15;

    // Write-permission class of each control bit position.
    function automatic wr_class_e bit_class(input int idx);
        if (idx >= RSV_LO && idx <= RSV_HI)
            return WR_NEVER;
        if (idx == BIT_AUTO_HALT || idx == BIT_ID_ORDER)
            return WR_RESET_ONLY;
        if (idx >= TEST_LO && idx <= TEST_HI)
            return WR_RESET_HALT;
        return WR_ANY;
    endfunction

endpackage

// File: rtl/mcr_regfile.sv
// Module: mode control word storage.
// Applies the per-bit write permissions using the mode that holds in the
// cycle of the write. Lets the auto-halt path set the halt request bit.
// Assumes mode is the combinational mode of the same cycle.
module mcr_regfile
    import busoff_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_mode_e        mode,
    input  logic             wr_en,
    input  logic [MCR_W-1:0] wdata,
    input  logic             auto_halt_set,
    output logic [MCR_W-1:0] q
);

    logic             in_reset_mode;
    logic             in_halt_mode;
    logic [MCR_W-1:0] allow;
    logic [MCR_W-1:0] set_mask;
    logic [MCR_W-1:0] written;

    // Mode qualifiers used by the permission classes.
    assign in_reset_mode = (mode == MODE_RESET);
    assign in_halt_mode  = (mode == MODE_HALT);

    // Per-bit write permission, chosen by the bit's class.
    for (genvar i = 0; i < MCR_W; i++) begin : g_bit
        localparam wr_class_e CLS = bit_class(i);
        if (CLS == WR_ANY) begin : g_any
            assign allow[i] = 1'b1;
        end else if (CLS == WR_RESET_ONLY) begin : g_rst
            assign allow[i] = in_reset_mode;
        end else if (CLS == WR_RESET_HALT) begin : g_rh
            assign allow[i] = in_reset_mode | in_halt_mode;
        end else begin : g_never
            assign allow[i] = 1'b0;
        end
    end

    // Merge permitted write bits and the automatic halt request.
    always_comb begin
        set_mask = '0;
        set_mask[BIT_HALT_REQ] = auto_halt_set;
        written  = wr_en ? ((q & ~allow) | (wdata & allow)) : q;
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= written | set_mask;
    end

endmodule

// File: rtl/recovery_counter.sv
// Module: bus-off recovery sequence counter.
// Counts runs of RUN_LEN recessive bit ticks. A dominant tick restarts the
// run without losing finished runs. Flags the tick that completes run number
// SEQ_COUNT. Progress is cleared whenever active is low.
module recovery_counter #(
    parameter int RUN_LEN   = 11,
    parameter int SEQ_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic recessive,
    output logic done_pulse
);

    localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam int SEQ_W = (SEQ_COUNT > 1) ? $clog2(SEQ_COUNT) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_COUNT - 1);

    logic [RUN_W-1:0] run_cnt;
    logic [SEQ_W-1:0] seq_cnt;
    logic             run_end;

    // A recessive tick that closes the current run.
    assign run_end    = active & tick & recessive & (run_cnt == RUN_LAST);
    // The closing tick of the final run.
    assign done_pulse = run_end & (seq_cnt == SEQ_LAST);

    // Run and sequence counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            run_cnt <= '0;
            seq_cnt <= '0;
        end else if (tick) begin
            if (!recessive) begin
                run_cnt <= '0;
            end else if (run_end) begin
                run_cnt <= '0;
                seq_cnt <= (seq_cnt == SEQ_LAST) ? '0 : seq_cnt + 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mode_ctrl.sv
// Module: operating mode tracker.
// Holds the reset-mode and bus-off flags and derives the reported mode.
// Decides between the bus-off and auto-halt paths on bus-off entry.
// Registers the recovery-complete pulse. Assumes the control bits come
// straight from the control word register.
module mode_ctrl
    import busoff_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_rst_req,
    input  logic      halt_req,
    input  logic      auto_halt_en,
    input  logic      halt_en,
    input  logic      busoff_enter,
    input  logic      recov_pulse,
    output ctl_mode_e mode,
    output logic      auto_halt_set,
    output logic      recovery_done
);

    logic in_reset;
    logic busoff;
    logic enter_ok;

    // Mode decode: reset, then halt, then bus-off, then normal.
    always_comb begin
        if (in_reset)
            mode = MODE_RESET;
        else if (halt_req)
            mode = MODE_HALT;
        else if (busoff)
            mode = MODE_BUSOFF;
        else
            mode = MODE_NORMAL;
    end

    // Bus-off entry only counts in normal mode; pick halt or recovery.
    assign enter_ok      = busoff_enter & (mode == MODE_NORMAL);
    assign auto_halt_set = enter_ok & auto_halt_en & halt_en;

    // Reset-mode flag follows the reset request bit of each write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_reset <= 1'b1;
        else if (wr_en)
            in_reset <= wr_rst_req;
    end

    // Bus-off flag: set on plain entry, cleared by reset mode or recovery.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_RESET)
            busoff <= 1'b0;
        else if (recov_pulse)
            busoff <= 1'b0;
        else if (enter_ok && !auto_halt_set)
            busoff <= 1'b1;
    end

    // One-cycle completion flag, aligned with the return to normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            recovery_done <= 1'b0;
        else
            recovery_done <= recov_pulse;
    end

endmodule

// File: rtl/can_busoff_recovery.sv
// Module: CAN bus-off recovery controller top.
// Connects the control word, the mode tracker and the recovery counter.
// Assumes bit_tick is a single-cycle strobe and bus_bit is already sampled.
module can_busoff_recovery
    import busoff_pkg::*;
#(
    parameter int RUN_LEN   = 11,
    parameter int SEQ_COUNT = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        bus_bit,
    input  logic        busoff_enter,
    input  logic        mcr_wr_en,
    input  logic [15:0] mcr_wdata,
    output logic [15:0] mcr_rdata,
    output logic [1:0]  mode_out,
    output logic        recovery_done
);

    ctl_mode_e        mode;
    logic [MCR_W-1:0] mcr_q;
    logic             auto_halt_set;
    logic             recov_pulse;

    mcr_regfile u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .wr_en         (mcr_wr_en),
        .wdata         (mcr_wdata),
        .auto_halt_set (auto_halt_set),
        .q             (mcr_q)
    );

    mode_ctrl u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (mcr_wr_en),
        .wr_rst_req    (mcr_wdata[BIT_RST_REQ]),
        .halt_req      (mcr_q[BIT_HALT_REQ]),
        .auto_halt_en  (mcr_q[BIT_AUTO_HALT]),
        .halt_en       (mcr_q[BIT_HALT_EN]),
        .busoff_enter  (busoff_enter),
        .recov_pulse   (recov_pulse),
        .mode          (mode),
        .auto_halt_set (auto_halt_set),
        .recovery_done (recovery_done)
    );

    recovery_counter #(
        .RUN_LEN   (RUN_LEN),
        .SEQ_COUNT (SEQ_COUNT)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (mode == MODE_BUSOFF),
        .tick       (bit_tick),
        .recessive  (bus_bit),
        .done_pulse (recov_pulse)
    );

    // Output views.
    assign mcr_rdata = mcr_q;
    assign mode_out  = mode;

endmodule

// File: rtl/busoff_recovery_chk.sv
// Checker: port-level temporal properties of can_busoff_recovery.
module busoff_recovery_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busoff_enter,
    input logic        mcr_wr_en,
    input logic [15:0] mcr_rdata,
    input logic [1:0]  mode_out,
    input logic        recovery_done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mode_out == 2'd0 && mcr_rdata == 16'h0000 && !recovery_done));

    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[13:11] == 3'b000);

    // R4
    lock_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_wr_en && mode_out != 2'd0) |=> $stable(mcr_rdata[15:14]));

    // R5
    lock_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_wr_en && mode_out[1]) |=> $stable(mcr_rdata[10:8]));

    // R7
    busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mcr_wr_en && busoff_enter && mode_out == 2'd2 &&
         !(mcr_rdata[14] && mcr_rdata[6])) |=> mode_out == 2'd3);

    // R8
    auto_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mcr_wr_en && busoff_enter && mode_out == 2'd2 &&
         mcr_rdata[14] && mcr_rdata[6]) |=> (mode_out == 2'd1 && mcr_rdata[1]));

    // R9
    done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recovery_done && $past(!mcr_wr_en)) |-> (mode_out == 2'd2 && $past(mode_out) == 2'd3));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_done |=> !recovery_done);

endmodule

bind can_busoff_recovery busoff_recovery_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busoff_enter  (busoff_enter),
    .mcr_wr_en     (mcr_wr_en),
    .mcr_rdata     (mcr_rdata),
    .mode_out      (mode_out),
    .recovery_done (recovery_done)
);

// File: tb/sim_can_busoff_recovery.sv
`timescale 1ns/1ps
module sim_can_busoff_recovery;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        bus_bit = 1'b1;
    logic        busoff_enter = 1'b0;
    logic        mcr_wr_en = 1'b0;
    logic [15:0] mcr_wdata = 16'h0;
    logic [15:0] mcr_rdata;
    logic [1:0]  mode_out;
    logic        recovery_done;

    int errors = 0;
    int checks = 0;
    bit started = 0;

    // Reference model state.
    int          m_run = 0;
    int          m_seq = 0;
    logic [15:0] m_reg = 16'h0;
    bit          m_in_reset = 1;
    bit          m_busoff = 0;
    bit          m_done = 0;

    always #2 clk = ~clk;

    can_busoff_recovery u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .bus_bit       (bus_bit),
        .busoff_enter  (busoff_enter),
        .mcr_wr_en     (mcr_wr_en),
        .mcr_wdata     (mcr_wdata),
        .mcr_rdata     (mcr_rdata),
        .mode_out      (mode_out),
        .recovery_done (recovery_done)
    );

    function automatic int m_mode();
        if (m_in_reset) return 0;
        if (m_reg[1])   return 1;
        if (m_busoff)   return 3;
        return 2;
    endfunction

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin : model
        int          md;
        logic [15:0] nreg;
        bit          ok;
        started = 1;
        md = m_mode();
        if (!rst_n) begin
            m_reg = 16'h0; m_in_reset = 1; m_busoff = 0;
            m_run = 0; m_seq = 0; m_done = 0;
        end else begin
            m_done = 0;
            nreg = m_reg;
            if (mcr_wr_en) begin
                for (int b = 0; b < 16; b++) begin
                    if (b >= 11 && b <= 13) ok = 0;
                    else if (b >= 14)       ok = (md == 0);
                    else if (b >= 8)        ok = (md <= 1);
                    else                    ok = 1;
                    if (ok) nreg[b] = mcr_wdata[b];
                end
                m_in_reset = mcr_wdata[0];
            end
            if (md == 0) m_busoff = 0;
            if (busoff_enter && md == 2) begin
                if (m_reg[14] && m_reg[6]) nreg[1] = 1'b1;
                else m_busoff = 1;
            end
            if (md == 3) begin
                if (bit_tick) begin
                    if (bus_bit) begin
                        m_run++;
                        if (m_run == 11) begin
                            m_run = 0;
                            m_seq++;
                            if (m_seq == 128) begin
                                m_seq = 0; m_busoff = 0; m_done = 1;
                            end
                        end
                    end else begin
                        m_run = 0;
                    end
                end
            end else begin
                m_run = 0; m_seq = 0;
            end
            m_reg = nreg;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            check("R2 mode vs model", {30'h0, mode_out}, m_mode());
            check("R4/R5/R6 word vs model", {16'h0, mcr_rdata}, {16'h0, m_reg});
            check("R9 done vs model", {31'h0, recovery_done}, {31'h0, m_done});
        end
    end

    task automatic wr(input logic [15:0] v);
        @(negedge clk); mcr_wr_en = 1'b1; mcr_wdata = v;
        @(negedge clk); mcr_wr_en = 1'b0;
    endtask

    task automatic enter_busoff();
        @(negedge clk); busoff_enter = 1'b1;
        @(negedge clk); busoff_enter = 1'b0;
    endtask

    // One strobe, then a non-strobe cycle carrying a dominant level.
    task automatic send(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1; bus_bit = lvl;
            @(negedge clk); bit_tick = 1'b0; bus_bit = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset mode", {30'h0, mode_out}, 0);
        check("R1 reset word", {16'h0, mcr_rdata}, 0);
        check("R1 reset done", {31'h0, recovery_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays reset", {30'h0, mode_out}, 0);

        // R3, R4, R5: everything but reserved bits writable in reset mode
        wr(16'hFFFF);
        check("R3 reserved zero", {16'h0, mcr_rdata}, 32'hC7FF);
        check("R1 bit0 keeps reset", {30'h0, mode_out}, 0);
        wr(16'h0040);
        check("R2 normal mode", {30'h0, mode_out}, 2);
        check("R4 cleared in reset", {16'h0, mcr_rdata}, 32'h0040);

        // R4, R5: locked in normal mode
        wr(16'hC740);
        check("R4 R5 locked in normal", {16'h0, mcr_rdata}, 32'h0040);

        // R5: writable in halt, R4 still locked
        wr(16'h0042);
        check("R2 halt mode", {30'h0, mode_out}, 1);
        wr(16'hC542);
        check("R5 test field in halt", {16'h0, mcr_rdata}, 32'h0542);
        wr(16'h05A0);
        check("R6 low bits any mode", {16'h0, mcr_rdata}, 32'h05A0);
        check("R2 back to normal", {30'h0, mode_out}, 2);
        wr(16'h0224);
        check("R5 R6 normal write", {16'h0, mcr_rdata}, 32'h0524);

        // R7: plain bus-off entry, repeated pulse ignored
        enter_busoff();
        check("R7 busoff entry", {30'h0, mode_out}, 3);
        enter_busoff();
        check("R7 repeat ignored", {30'h0, mode_out}, 3);

        // R9: uninterrupted recovery
        send(1407, 1'b1);
        check("R9 not yet done", {30'h0, mode_out}, 3);
        send(1, 1'b1);
        check("R9 done pulse", {31'h0, recovery_done}, 1);
        check("R9 normal after", {30'h0, mode_out}, 2);
        @(negedge clk);
        check("R9 single pulse", {31'h0, recovery_done}, 0);

        // R10: dominant bits break runs, keep finished sequences
        enter_busoff();
        send(10, 1'b1);
        send(1, 1'b0);
        send(38, 1'b1);
        send(1, 1'b0);
        send(1374, 1'b1);
        check("R10 partial runs lost", {30'h0, mode_out}, 3);
        send(1, 1'b1);
        check("R10 done at expected tick", {31'h0, recovery_done}, 1);

        // R7: entry ignored in reset mode
        wr(16'h0001);
        wr(16'h4041);
        enter_busoff();
        check("R7 ignored in reset", {30'h0, mode_out}, 0);

        // R8: auto-halt path
        wr(16'h4040);
        enter_busoff();
        check("R8 halt mode", {30'h0, mode_out}, 1);
        check("R8 halt bit set", {16'h0, mcr_rdata}, 32'h4042);

        // R7: auto-halt bit alone does not halt
        wr(16'h0000);
        check("R4 auto-halt kept in halt", {16'h0, mcr_rdata}, 32'h4000);
        enter_busoff();
        check("R7 busoff with bit6 clear", {30'h0, mode_out}, 3);
        send(20, 1'b1);

        // R11: reset mode clears bus-off and progress
        wr(16'h4001);
        check("R11 reset mode", {30'h0, mode_out}, 0);
        wr(16'h4000);
        check("R11 normal after reset", {30'h0, mode_out}, 2);
        enter_busoff();
        send(1407, 1'b1);
        check("R11 full count needed", {30'h0, mode_out}, 3);
        send(1, 1'b1);
        check("R11 done after full count", {31'h0, recovery_done}, 1);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule